// File: doc/BRIEF.md
# Bus-Master Descriptor DMA Channel

This block is one channel of a bus-master disk DMA controller. Software programs a small register window: a command byte that starts or stops the engine and selects the transfer direction, a status byte with an active flag, an error flag and an interrupt flag, and a pointer to a table of region descriptors in memory. A storage device that wants a DMA transfer holds a request line high. While the channel is active and the device request is present, the engine walks the descriptor table. Each descriptor is read as two 32-bit words through a request/acknowledge memory read port.

For each region, the engine offers the device a grant. The grant carries the current buffer address, the remaining length and the direction. The device answers with the number of bytes it moved. The engine advances the address and reduces the remaining length until the region is empty. It then fetches the next descriptor. The walk ends in three cases: after a descriptor flagged as the last one, when the device reports that it moved nothing, or after a fixed maximum number of descriptors. At the end, the channel drops its active flag, raises its interrupt flag and pulses a release to the device.

A second channel is a second instance, with its register window placed 8 bytes higher by the surrounding decode.

Top module: `bmide_channel`

## Requirements
- R1: Writing the command register (offset 0) stores only bit 0 (start) and bit 3 (direction). Reading it back returns the written value ANDed with 0x09.
- R2: A command write with bit 0 set sets status bit 0 (active). A command write with bit 0 clear clears it.
- R3: A status write (offset 2) has three effects. It stores written bits 5 and 6 directly. It leaves bit 0 unchanged. It clears bit 1 (error) and bit 2 (interrupt) wherever the written value has a 1. Other status bits read 0.
- R4: Writing the table pointer (offset 4) forces its two low bits to zero, and it reads back that way.
- R5: The walk reads the descriptor at pointer P as two memory words. The word at P is the buffer address. The word at P+4 holds the count in bits 15:1, with bit 0 ignored, so every region length is even. Descriptors are fetched at P, P+8, P+16, and so on.
- R6: A count field of zero gives a 65536-byte region.
- R7: A descriptor with bit 31 of its count word set ends the walk once its region has been transferred.
- R8: When the device answers a grant with zero bytes, the walk ends at once.
- R9: The walk processes at most MAX_PRD descriptors (default 512), then ends even though no last flag has been seen.
- R10: At the end of the walk, three things happen together. The active bit clears, the interrupt bit sets, and dev_release pulses for exactly one cycle. The irq output equals status bit 2.
- R11: The walk starts when the channel is active and dev_req is high, in either order. A device request alone does not fetch anything while the channel is inactive.
- R12: A partial answer of N bytes advances the grant address by N and reduces the granted length by N. The engine keeps granting the same region until it is empty.
- R13: dev_grant_dir equals command bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset within the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Memory read acknowledge, with data valid |
| mem_rdata | input | 32 | Memory read data |
| dev_req | input | 1 | Device requests a DMA transfer |
| dev_grant | output | 1 | Region grant offered to the device |
| dev_grant_addr | output | 32 | Buffer address for the grant |
| dev_grant_len | output | 17 | Bytes remaining in the region |
| dev_grant_dir | output | 1 | Transfer direction (command bit 3) |
| dev_ack | input | 1 | Device answers the grant |
| dev_taken | input | 17 | Bytes moved by the device; 0 means exhausted |
| dev_release | output | 1 | One-cycle pulse at walk completion |
| irq | output | 1 | Interrupt, equal to status bit 2 |

## Verification
A register write takes effect at the rising edge that samples it. The bench reads reg_rdata combinationally after the next falling edge and checks it there. A walk starts with mem_req in the cycle after the edge at which both active and dev_req are seen. Each memory or device handshake then costs two cycles in the bench models. dev_release is high in the cycle after the final device or memory answer, and irq rises one edge later. The bench therefore waits for irq with a bounded falling-edge loop. Only after that does it compare the logged fetch addresses, grant counts, byte totals and status. It samples every output at falling edges, away from the active edge.

// File: rtl/bmide_pkg.sv
package bmide_pkg;

    localparam logic [2:0] OFS_CMD = 3'd0;
    localparam logic [2:0] OFS_STS = 3'd2;
    localparam logic [2:0] OFS_TBL = 3'd4;

    localparam logic [7:0] CMD_KEEP   = 8'h09;
    localparam int         CMD_RUN    = 0;
    localparam int         CMD_DIR    = 3;
    localparam int         STS_ACT    = 0;
    localparam int         STS_IRQ    = 2;
    localparam logic [7:0] STS_SOFT   = 8'h60;
    localparam logic [7:0] STS_STICKY = 8'h06;

    localparam int         LEN_W      = 17;
    localparam int         LAST_BIT   = 31;

    typedef enum logic [2:0] {
        W_IDLE,
        W_FADDR,
        W_FCNT,
        W_XFER,
        W_DONE
    } walk_state_e;

    typedef struct packed {
        logic [31:0]      addr;
        logic [LEN_W-1:0] remain;
        logic             last;
    } region_t;

    function automatic logic [LEN_W-1:0] region_len(input logic [15:0] lo);
        logic [LEN_W-1:0] l;
        l = {1'b0, lo[15:1], 1'b0};
        if (lo[15:1] == 15'd0) l = 17'h10000;
        return l;
    endfunction

endpackage

// File: rtl/bmide_regs.sv
module bmide_regs
    import bmide_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    input  logic        done,
    output logic [31:0] rdata,
    output logic        active,
    output logic        dir,
    output logic [31:0] tbl_ptr,
    output logic [7:0]  status
);
    logic [7:0]  cmd_q;
    logic [7:0]  st_q;
    logic [31:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= 8'h00;
            st_q  <= 8'h00;
            ptr_q <= 32'h0;
        end else begin
            if (done) begin
                st_q[STS_ACT] <= 1'b0;
                st_q[STS_IRQ] <= 1'b1;
            end
            if (wr) begin
                case (addr)
                    OFS_CMD: begin
                        cmd_q         <= wdata[7:0] & CMD_KEEP;
                        st_q[STS_ACT] <= wdata[CMD_RUN];
                    end
                    OFS_STS: begin
                        st_q <= (wdata[7:0] & STS_SOFT)
                              | (st_q & 8'h01)
                              | (st_q & ~wdata[7:0] & STS_STICKY);
                    end
                    OFS_TBL: ptr_q <= {wdata[31:2], 2'b00};
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_CMD: rdata = {24'h0, cmd_q};
            OFS_STS: rdata = {24'h0, st_q};
            OFS_TBL: rdata = ptr_q;
            default: rdata = 32'h0;
        endcase
    end

    assign active  = st_q[STS_ACT];
    assign dir     = cmd_q[CMD_DIR];
    assign tbl_ptr = ptr_q;
    assign status  = st_q;
endmodule

// File: rtl/bmide_walker.sv
module bmide_walker
    import bmide_pkg::*;
#(
    parameter int MAX_PRD = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [31:0]      tbl_ptr,
    output logic             idle,
    output logic             done,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             dev_grant,
    output logic [31:0]      dev_grant_addr,
    output logic [LEN_W-1:0] dev_grant_len,
    input  logic             dev_ack,
    input  logic [LEN_W-1:0] dev_taken
);
    localparam int ENT_W = $clog2(MAX_PRD + 1);
    localparam logic [ENT_W-1:0] ENT_CAP = ENT_W'(MAX_PRD);

    walk_state_e      state_q;
    region_t          rg_q;
    logic [31:0]      cur_q;
    logic [ENT_W-1:0] ent_q;
    logic [LEN_W-1:0] take;
    logic [LEN_W-1:0] left;
    logic             unused_rsvd;

    assign unused_rsvd = ^mem_rdata[30:16];
    assign take = (dev_taken > rg_q.remain) ? rg_q.remain : dev_taken;
    assign left = rg_q.remain - take;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_IDLE;
            rg_q    <= '0;
            cur_q   <= 32'h0;
            ent_q   <= '0;
        end else begin
            case (state_q)
                W_IDLE: if (go) begin
                    cur_q   <= tbl_ptr;
                    ent_q   <= '0;
                    state_q <= W_FADDR;
                end
                W_FADDR: if (mem_ack) begin
                    rg_q.addr <= mem_rdata;
                    state_q   <= W_FCNT;
                end
                W_FCNT: if (mem_ack) begin
                    rg_q.remain <= region_len(mem_rdata[15:0]);
                    rg_q.last   <= mem_rdata[LAST_BIT];
                    ent_q       <= ent_q + 1'b1;
                    state_q     <= W_XFER;
                end
                W_XFER: if (dev_ack) begin
                    if (dev_taken == '0) begin
                        state_q <= W_DONE;
                    end else begin
                        rg_q.addr   <= rg_q.addr + 32'(take);
                        rg_q.remain <= left;
                        if (left == '0) begin
                            if (rg_q.last || ent_q == ENT_CAP) begin
                                state_q <= W_DONE;
                            end else begin
                                cur_q   <= cur_q + 32'd8;
                                state_q <= W_FADDR;
                            end
                        end
                    end
                end
                W_DONE:  state_q <= W_IDLE;
                default: state_q <= W_IDLE;
            endcase
        end
    end

    assign idle           = (state_q == W_IDLE);
    assign done           = (state_q == W_DONE);
    assign mem_req        = (state_q == W_FADDR) || (state_q == W_FCNT);
    assign mem_addr       = (state_q == W_FCNT) ? cur_q + 32'd4 : cur_q;
    assign dev_grant      = (state_q == W_XFER);
    assign dev_grant_addr = rg_q.addr;
    assign dev_grant_len  = rg_q.remain;
endmodule

// File: rtl/bmide_channel.sv
module bmide_channel
    import bmide_pkg::*;
#(
    parameter int MAX_PRD = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        dev_req,
    output logic        dev_grant,
    output logic [31:0] dev_grant_addr,
    output logic [16:0] dev_grant_len,
    output logic        dev_grant_dir,
    input  logic        dev_ack,
    input  logic [16:0] dev_taken,
    output logic        dev_release,
    output logic        irq
);
    logic        active;
    logic        dir;
    logic [31:0] tbl_ptr;
    logic [7:0]  status_w;
    logic        idle;
    logic        done;
    logic        go;

    bmide_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .done   (done),
        .rdata  (reg_rdata),
        .active (active),
        .dir    (dir),
        .tbl_ptr(tbl_ptr),
        .status (status_w)
    );

    assign go = active && dev_req && idle;

    bmide_walker #(.MAX_PRD(MAX_PRD)) u_walk (
        .clk           (clk),
        .rst           (rst),
        .go            (go),
        .tbl_ptr       (tbl_ptr),
        .idle          (idle),
        .done          (done),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .dev_grant     (dev_grant),
        .dev_grant_addr(dev_grant_addr),
        .dev_grant_len (dev_grant_len),
        .dev_ack       (dev_ack),
        .dev_taken     (dev_taken)
    );

    assign dev_grant_dir = dir;
    assign dev_release   = done;
    assign irq           = status_w[STS_IRQ];
endmodule

// File: rtl/bmide_channel_chk.sv
module bmide_channel_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        dev_grant,
    input logic [31:0] dev_grant_addr,
    input logic [16:0] dev_grant_len,
    input logic        dev_ack,
    input logic        dev_release,
    input logic        irq,
    input logic [7:0]  status
);
    p_mem_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_mem_align_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_grant_len_r6: assert property (@(posedge clk) disable iff (rst)
        dev_grant |-> (dev_grant_len != 17'd0 && dev_grant_len <= 17'h10000
                       && dev_grant_len[0] == 1'b0));

    p_grant_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (dev_grant && !dev_ack) |=> (dev_grant && $stable(dev_grant_addr)
                                     && $stable(dev_grant_len)));

    p_release_irq_r10: assert property (@(posedge clk) disable iff (rst)
        dev_release |=> (irq && !status[0]));

    p_release_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        dev_release |=> !dev_release);

    p_no_overlap_r11: assert property (@(posedge clk) disable iff (rst)
        !(dev_grant && mem_req));
endmodule

bind bmide_channel bmide_channel_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_ack       (mem_ack),
    .dev_grant     (dev_grant),
    .dev_grant_addr(dev_grant_addr),
    .dev_grant_len (dev_grant_len),
    .dev_ack       (dev_ack),
    .dev_release   (dev_release),
    .irq           (irq),
    .status        (status_w)
);

// File: tb/test_bmide_channel.sv
module test_bmide_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'h0;
    logic        dev_req = 1'b0;
    logic        dev_grant;
    logic [31:0] dev_grant_addr;
    logic [16:0] dev_grant_len;
    logic        dev_grant_dir;
    logic        dev_ack = 1'b0;
    logic [16:0] dev_taken = 17'd0;
    logic        dev_release;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // memory model state
    logic [31:0] tbl_base = 32'h0;
    bit          cap_mode = 0;
    logic [31:0] tbl_a [8];
    logic [31:0] tbl_w [8];
    int          m_n = 0;
    int          m_bad = 0;
    logic [31:0] m_last = 32'h0;

    // device model state
    int          chunk = 32'h20000;
    int          budget = 32'h7fffffff;
    int          g_n = 0;
    int          g_total = 0;
    logic [31:0] g_first_addr, g_last_addr;
    logic [16:0] g_first_len, g_last_len;
    logic        g_dir;
    int          rel_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmide_channel i_bmide_channel (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_req(dev_req), .dev_grant(dev_grant), .dev_grant_addr(dev_grant_addr),
        .dev_grant_len(dev_grant_len), .dev_grant_dir(dev_grant_dir),
        .dev_ack(dev_ack), .dev_taken(dev_taken),
        .dev_release(dev_release), .irq(irq)
    );

    function automatic logic [31:0] lookup(input logic [31:0] a);
        int idx;
        idx = int'((a - tbl_base) >> 2);
        if (cap_mode) begin
            if (idx[0]) return 32'h0000_0002;
            return 32'h1000_0000 + 32'((idx >> 1) * 256);
        end
        if ((idx >> 1) >= 8 || idx < 0) return 32'h0;
        return idx[0] ? tbl_w[idx >> 1] : tbl_a[idx >> 1];
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (mem_addr != tbl_base + 32'(4 * m_n)) m_bad++;
                m_last    = mem_addr;
                m_n++;
                mem_rdata = lookup(mem_addr);
                mem_ack   = 1'b1;
            end
            if (dev_ack) dev_ack = 1'b0;
            else if (dev_grant) begin
                int t;
                g_n++;
                if (g_n == 1) begin
                    g_first_addr = dev_grant_addr;
                    g_first_len  = dev_grant_len;
                end
                g_last_addr = dev_grant_addr;
                g_last_len  = dev_grant_len;
                g_dir       = dev_grant_dir;
                t = int'(dev_grant_len);
                if (t > chunk)  t = chunk;
                if (t > budget) t = budget;
                budget   -= t;
                g_total  += t;
                dev_taken = 17'(t);
                dev_ack   = 1'b1;
            end
            if (dev_release) rel_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_logs();
        m_n = 0; m_bad = 0; g_n = 0; g_total = 0; rel_n = 0;
        chunk = 32'h20000; budget = 32'h7fffffff; cap_mode = 0;
    endtask

    task automatic wait_end(input string req);
        int k;
        k = 0;
        while (!irq && k < 10000) begin
            @(negedge clk);
            k++;
        end
        chk(req, {31'h0, irq}, 32'h1);
        dev_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd_reg(3'd0, d); chk("R1 reset cmd", d, 32'h0);
        rd_reg(3'd2, d); chk("R2 reset status", d, 32'h0);
        rd_reg(3'd4, d); chk("R4 reset ptr", d, 32'h0);
        chk("R10 reset irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr_reg(3'd0, 32'hFF);
        rd_reg(3'd0, d); chk("R1 cmd mask", d, 32'h09);
        rd_reg(3'd2, d); chk("R2 start sets active", d, 32'h01);
        wr_reg(3'd2, 32'hFE);
        rd_reg(3'd2, d); chk("R3 soft bits, active kept", d, 32'h61);
        wr_reg(3'd0, 32'h08);
        rd_reg(3'd2, d); chk("R2 stop clears active", d, 32'h60);
        rd_reg(3'd0, d); chk("R1 cmd dir only", d, 32'h08);
        wr_reg(3'd2, 32'h00);
        rd_reg(3'd2, d); chk("R3 soft bits cleared", d, 32'h00);
        wr_reg(3'd4, 32'hFFFF_FFFF);
        rd_reg(3'd4, d); chk("R4 ptr aligned", d, 32'hFFFF_FFFC);
        chk("R11 no fetch while idle", 32'(m_n), 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        clear_logs();
        tbl_base = 32'h100;
        tbl_a[0] = 32'h2000; tbl_w[0] = 32'h0000_0010;
        tbl_a[1] = 32'h3000; tbl_w[1] = 32'h8000_0021;
        wr_reg(3'd4, 32'h100);
        dev_req = 1'b1;
        repeat (6) @(negedge clk);
        chk("R11 bind without start no fetch", 32'(m_n), 32'd0);
        wr_reg(3'd0, 32'h09);
        wait_end("R7 last flag ends walk");
        chk("R5 fetch count", 32'(m_n), 32'd4);
        chk("R5 fetch addresses", 32'(m_bad), 32'd0);
        chk("R5 grant count", 32'(g_n), 32'd2);
        chk("R5 first grant addr", g_first_addr, 32'h2000);
        chk("R5 first grant len", 32'(g_first_len), 32'd16);
        chk("R5 bit0 ignored len", 32'(g_last_len), 32'd32);
        chk("R12 total bytes", 32'(g_total), 32'd48);
        chk("R13 dir read", {31'h0, g_dir}, 32'h1);
        chk("R10 one release", 32'(rel_n), 32'd1);
        rd_reg(3'd2, d); chk("R10 status after end", d, 32'h04);
        wr_reg(3'd2, 32'h60);
        rd_reg(3'd2, d); chk("R3 zero in irq keeps it", d, 32'h64);
        wr_reg(3'd2, 32'h04);
        rd_reg(3'd2, d); chk("R3 w1c irq", d, 32'h00);
        chk("R10 irq follows status", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_zero_len();
        clear_logs();
        tbl_base = 32'h200;
        tbl_a[0] = 32'h4000; tbl_w[0] = 32'h8000_0000;
        chunk = 32'h4000;
        wr_reg(3'd4, 32'h200);
        wr_reg(3'd0, 32'h01);
        repeat (6) @(negedge clk);
        chk("R11 start without bind no fetch", 32'(m_n), 32'd0);
        dev_req = 1'b1;
        wait_end("R6 walk ends");
        chk("R6 first grant len 64K", 32'(g_first_len), 32'h10000);
        chk("R12 partial grants", 32'(g_n), 32'd4);
        chk("R12 last grant addr", g_last_addr, 32'h10000);
        chk("R12 last grant len", 32'(g_last_len), 32'h4000);
        chk("R6 total bytes", 32'(g_total), 32'h10000);
        chk("R13 dir write", {31'h0, g_dir}, 32'h0);
        wr_reg(3'd2, 32'h04);
    endtask

    task automatic t_exhaust();
        clear_logs();
        tbl_base = 32'h300;
        tbl_a[0] = 32'h5000; tbl_w[0] = 32'h0000_0100;
        tbl_a[1] = 32'h6000; tbl_w[1] = 32'h0000_0100;
        tbl_a[2] = 32'h7000; tbl_w[2] = 32'h0000_0100;
        budget = 32'h180;
        wr_reg(3'd4, 32'h300);
        dev_req = 1'b1;
        wr_reg(3'd0, 32'h01);
        wait_end("R8 exhaustion ends walk");
        chk("R8 grants", 32'(g_n), 32'd3);
        chk("R8 fetches", 32'(m_n), 32'd4);
        chk("R12 resumed addr", g_last_addr, 32'h6080);
        chk("R12 resumed len", 32'(g_last_len), 32'd128);
        chk("R8 total", 32'(g_total), 32'h180);
        wr_reg(3'd2, 32'h04);
    endtask

    task automatic t_cap();
        clear_logs();
        cap_mode = 1;
        tbl_base = 32'h8000;
        wr_reg(3'd4, 32'h8000);
        dev_req = 1'b1;
        wr_reg(3'd0, 32'h01);
        wait_end("R9 cap ends walk");
        chk("R9 grants", 32'(g_n), 32'd512);
        chk("R9 fetches", 32'(m_n), 32'd1024);
        chk("R9 last fetch addr", m_last, 32'h8FFC);
        chk("R9 total", 32'(g_total), 32'd1024);
        chk("R10 one release", 32'(rel_n), 32'd1);
        wr_reg(3'd2, 32'h04);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_basic();
        t_zero_len();
        t_exhaust();
        t_cap();
        finish_run();
    end
endmodule